// File: doc/BRIEF.md
# Shadow Region Register Access Filter

This block sits on a simple register bus and serves one small set of per-channel control registers through several address windows. The global channel window shows every channel bit. Each of the shadow windows belongs to one region, and a region is normally handed to one software master. An access through a shadow window is filtered bit by bit. For registers that hold DMA channel bits, the filter is that region's DMA ownership mask. For registers that hold QDMA channel bits, it is that region's separate QDMA ownership mask. A masked bit reads as zero, and a write leaves it unchanged.

The ownership masks are global registers. They are reachable only at their fixed global offsets and never through a shadow window. The channel registers are a DMA event-enable register with set and clear aliases, a QDMA event-enable register with the same two aliases, and a re-evaluate strobe. The strobe is exempt from masking. A write through any window fires it whatever the masks hold.

Top module: `shadow_region_filter`

## Requirements
- R1: After a synchronous active-low reset, all ownership masks, `evt_enable`, `qevt_enable`, `reeval_pulse`, `bus_rdata` and `bus_err` are zero.
- R2: The global channel window spans 0x1000–0x11FF. Shadow region n (n = 0..3) spans 0x2000 + n·0x200 for 0x200 bytes. Inside a window, the local offsets are: DMA enable 0x020, its clear alias 0x028, its set alias 0x030, re-evaluate 0x070, QDMA enable 0x080, its clear alias 0x088, its set alias 0x08C.
- R3: An access through the global window reads and writes every bit of the addressed register.
- R4: A shadow read of the DMA enable returns its value ANDed with the region's DMA mask.
- R5: A shadow write to the DMA enable changes only the bits where the region's DMA mask is 1.
- R6: A 1 written to a set alias sets that bit, and a 1 written to a clear alias clears it. Written 0s have no effect. Through a shadow window, only masked-in bits are affected. Both aliases read as zero.
- R7: The QDMA enable and its aliases use the region's 8-bit QDMA mask, which is independent of the DMA mask.
- R8: A write with data bit 0 = 1 to the re-evaluate offset, through any window, sets `reeval_pulse` high for exactly the next cycle, regardless of the masks. The offset reads as zero.
- R9: The DMA mask of region n is at global 0x0340 + 8n (32 bits). The QDMA mask of region n is at 0x0380 + 4n (bits 7:0, upper bits read zero). Neither is decoded inside any window.
- R10: An undecoded or non-word-aligned address reads zero and ignores the write. `bus_err` is high for exactly the cycle after the access.
- R11: `bus_rdata` is registered. It holds the read value in the cycle after a read request and zero after any non-read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Decode error, one cycle after the access |
| evt_enable | output | 32 | DMA event-enable register |
| qevt_enable | output | 8 | QDMA event-enable register |
| reeval_pulse | output | 1 | Re-evaluate strobe |

## Verification
The hardest case to reach is a shadow write that touches a mix of owned and unowned bits. Reaching it needs a register already holding a pattern that differs on both sides of the mask. The stimulus first loads a pattern through the global window, then programs a partial mask, then writes the complementary pattern through the shadow window. Reading back through the global window then shows the bits that changed and the bits that held. A region with an all-zero mask is used to confirm that a re-evaluate write still fires while alias writes do nothing.

// File: rtl/srf_pkg.sv
// Shared types and window-local offsets for the shadow region filter.
// Assumes 32-bit word-aligned registers and windows of 0x200 bytes.
package srf_pkg;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_EE, SEL_EE_CLR, SEL_EE_SET,
        SEL_QEE, SEL_QEE_CLR, SEL_QEE_SET,
        SEL_REEVAL, SEL_DMA_EN, SEL_QDMA_EN
    } reg_sel_e;

    localparam logic [8:0] LOC_EE      = 9'h020;
    localparam logic [8:0] LOC_EE_CLR  = 9'h028;
    localparam logic [8:0] LOC_EE_SET  = 9'h030;
    localparam logic [8:0] LOC_REEVAL  = 9'h070;
    localparam logic [8:0] LOC_QEE     = 9'h080;
    localparam logic [8:0] LOC_QEE_CLR = 9'h088;
    localparam logic [8:0] LOC_QEE_SET = 9'h08C;

    // Map a window-local offset to the channel register it names.
    function automatic reg_sel_e chan_sel(input logic [8:0] loc);
        case (loc)
            LOC_EE:      return SEL_EE;
            LOC_EE_CLR:  return SEL_EE_CLR;
            LOC_EE_SET:  return SEL_EE_SET;
            LOC_REEVAL:  return SEL_REEVAL;
            LOC_QEE:     return SEL_QEE;
            LOC_QEE_CLR: return SEL_QEE_CLR;
            LOC_QEE_SET: return SEL_QEE_SET;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/srf_decode.sv
// Address decoder: classifies a bus address as a global-window channel
// register, a shadow-window channel register with its region, or a global
// ownership mask register with its index. Assumes word alignment is required.
module srf_decode
    import srf_pkg::*;
#(
    parameter int AW       = 16,
    parameter int NREG     = 4,
    parameter int GLB_BASE = 32'h1000,
    parameter int SHD_BASE = 32'h2000,
    parameter int DEN_BASE = 32'h0340,
    parameter int QEN_BASE = 32'h0380,
    localparam int RW      = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int SPAN    = 32'h200
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel,
    output logic          shadow,
    output logic [RW-1:0] region,
    output logic [RW-1:0] idx
);

    int a;

    // Range compare the address against each window and register group.
    always_comb begin
        a      = int'(addr);
        sel    = SEL_NONE;
        shadow = 1'b0;
        region = '0;
        idx    = '0;
        if (addr[1:0] == 2'b00) begin
            if (a >= GLB_BASE && a < GLB_BASE + SPAN) begin
                sel = chan_sel(addr[8:0]);
            end else if (a >= SHD_BASE && a < SHD_BASE + NREG * SPAN) begin
                shadow = 1'b1;
                region = RW'((a - SHD_BASE) / SPAN);
                sel    = chan_sel(addr[8:0]);
            end else if (a >= DEN_BASE && a < DEN_BASE + NREG * 8 && addr[2] == 1'b0) begin
                sel = SEL_DMA_EN;
                idx = RW'((a - DEN_BASE) / 8);
            end else if (a >= QEN_BASE && a < QEN_BASE + NREG * 4) begin
                sel = SEL_QDMA_EN;
                idx = RW'((a - QEN_BASE) / 4);
            end
        end
    end

endmodule

// File: rtl/srf_owner_masks.sv
// Per-region ownership masks (DMA and QDMA). Written and read only through
// global offsets. Presents the addressed region's masks to the channel file.
module srf_owner_masks
    import srf_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NREG = 4,
    parameter int NCH  = 32,
    parameter int NQ   = 8,
    localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  reg_sel_e       sel,
    input  logic [RW-1:0]  idx,
    input  logic [RW-1:0]  region,
    input  logic [DW-1:0]  wdata,
    output logic [NCH-1:0] dmask,
    output logic [NQ-1:0]  qmask,
    output logic [DW-1:0]  rd_val
);

    logic [NCH-1:0] den_q [NREG];
    logic [NQ-1:0]  qen_q [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_region
        // Hold the two ownership masks of one region.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                den_q[r] <= '0;
                qen_q[r] <= '0;
            end else if (wr && idx == RW'(r)) begin
                if (sel == SEL_DMA_EN)  den_q[r] <= wdata[NCH-1:0];
                if (sel == SEL_QDMA_EN) qen_q[r] <= wdata[NQ-1:0];
            end
        end

        a_r9_den_only_global: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr && sel == SEL_DMA_EN && idx == RW'(r)) |=> $stable(den_q[r]));
        a_r9_qen_only_global: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr && sel == SEL_QDMA_EN && idx == RW'(r)) |=> $stable(qen_q[r]));
    end

    // Select the masks of the accessed region and the read-back value.
    always_comb begin
        dmask  = den_q[region];
        qmask  = qen_q[region];
        rd_val = '0;
        if (sel == SEL_DMA_EN)  rd_val[NCH-1:0] = den_q[idx];
        if (sel == SEL_QDMA_EN) rd_val[NQ-1:0]  = qen_q[idx];
    end

endmodule

// File: rtl/srf_chan_regs.sv
// Channel register file: DMA and QDMA event-enable registers with set/clear
// aliases, plus the re-evaluate strobe. Shadow accesses apply the supplied
// masks; global accesses see all bits; the strobe ignores masks.
module srf_chan_regs
    import srf_pkg::*;
#(
    parameter int DW  = 32,
    parameter int NCH = 32,
    parameter int NQ  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  reg_sel_e       sel,
    input  logic           shadow,
    input  logic [NCH-1:0] dmask,
    input  logic [NQ-1:0]  qmask,
    input  logic [DW-1:0]  wdata,
    output logic [NCH-1:0] ee_q,
    output logic [NQ-1:0]  qee_q,
    output logic           reeval_q,
    output logic [DW-1:0]  rd_val
);

    logic [NCH-1:0] dm, dw;
    logic [NQ-1:0]  qm, qw;

    // Effective masks: all ones through the global window.
    always_comb begin
        dm = shadow ? dmask : '1;
        qm = shadow ? qmask : '1;
        dw = wdata[NCH-1:0];
        qw = wdata[NQ-1:0];
        rd_val = '0;
        if (sel == SEL_EE)  rd_val[NCH-1:0] = ee_q & dm;
        if (sel == SEL_QEE) rd_val[NQ-1:0]  = qee_q & qm;
    end

    // Apply masked direct, set and clear writes; generate the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ee_q     <= '0;
            qee_q    <= '0;
            reeval_q <= 1'b0;
        end else begin
            reeval_q <= wr && sel == SEL_REEVAL && wdata[0];
            if (wr) begin
                case (sel)
                    SEL_EE:      ee_q  <= (ee_q & ~dm) | (dw & dm);
                    SEL_EE_SET:  ee_q  <= ee_q | (dw & dm);
                    SEL_EE_CLR:  ee_q  <= ee_q & ~(dw & dm);
                    SEL_QEE:     qee_q <= (qee_q & ~qm) | (qw & qm);
                    SEL_QEE_SET: qee_q <= qee_q | (qw & qm);
                    SEL_QEE_CLR: qee_q <= qee_q & ~(qw & qm);
                    default: ;
                endcase
            end
        end
    end

    // R5 / R6: unowned DMA bits hold across any shadow write.
    a_r5_dma_unowned_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && shadow && (sel == SEL_EE || sel == SEL_EE_SET || sel == SEL_EE_CLR))
        |=> (((ee_q ^ $past(ee_q)) & ~$past(dmask)) == '0));
    // R7: unowned QDMA bits hold across any shadow write.
    a_r7_qdma_unowned_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && shadow && (sel == SEL_QEE || sel == SEL_QEE_SET || sel == SEL_QEE_CLR))
        |=> (((qee_q ^ $past(qee_q)) & ~$past(qmask)) == '0));
    // R8: strobe fires regardless of masks, for one cycle.
    a_r8_reeval_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_REEVAL && wdata[0]) |=> reeval_q);
    a_r8_reeval_single: assert property (@(posedge clk) disable iff (!rst_n)
        (reeval_q && !(wr && sel == SEL_REEVAL && wdata[0])) |=> !reeval_q);

endmodule

// File: rtl/shadow_region_filter.sv
// Top: register bus front end. Decodes each single-cycle access, routes it
// to the ownership masks or the channel file, and registers read data and
// the decode error flag. Assumes at most one access per cycle.
module shadow_region_filter
    import srf_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int NREG = 4,
    parameter int NCH  = 32,
    parameter int NQ   = 8,
    localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_en,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           bus_err,
    output logic [NCH-1:0] evt_enable,
    output logic [NQ-1:0]  qevt_enable,
    output logic           reeval_pulse
);

    reg_sel_e       sel;
    logic           shadow, wr;
    logic [RW-1:0]  region, idx;
    logic [NCH-1:0] dmask;
    logic [NQ-1:0]  qmask;
    logic [DW-1:0]  rd_mask, rd_chan;

    srf_decode #(.AW(AW), .NREG(NREG)) dec_i (
        .addr(bus_addr), .sel(sel), .shadow(shadow), .region(region), .idx(idx)
    );

    assign wr = bus_en && bus_we && sel != SEL_NONE;

    srf_owner_masks #(.DW(DW), .NREG(NREG), .NCH(NCH), .NQ(NQ)) own_i (
        .clk(clk), .rst_n(rst_n), .wr(wr), .sel(sel), .idx(idx),
        .region(region), .wdata(bus_wdata), .dmask(dmask), .qmask(qmask),
        .rd_val(rd_mask)
    );

    srf_chan_regs #(.DW(DW), .NCH(NCH), .NQ(NQ)) chan_i (
        .clk(clk), .rst_n(rst_n), .wr(wr), .sel(sel), .shadow(shadow),
        .dmask(dmask), .qmask(qmask), .wdata(bus_wdata), .ee_q(evt_enable),
        .qee_q(qevt_enable), .reeval_q(reeval_pulse), .rd_val(rd_chan)
    );

    // Register read data and the decode error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= (bus_en && !bus_we) ? (rd_mask | rd_chan) : '0;
            bus_err   <= bus_en && sel == SEL_NONE;
        end
    end

    // R10: an error only follows an access.
    a_r10_err_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_en));
    // R10: undecoded reads return zero.
    a_r10_undecoded_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && sel == SEL_NONE) |=> bus_rdata == '0);
    // R11: no read request, zero read data next cycle.
    a_r11_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && !bus_we) |=> bus_rdata == '0);

endmodule

// File: tb/shadow_region_filter_tb.sv
`timescale 1ns/1ps
module shadow_region_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [31:0] evt_enable;
    logic [7:0]  qevt_enable;
    logic        reeval_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    shadow_region_filter dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .evt_enable(evt_enable), .qevt_enable(qevt_enable),
        .reeval_pulse(reeval_pulse)
    );

    // {we, addr, data (write data or expected read), expected err}
    localparam int NV = 29;
    localparam logic [49:0] VEC [NV] = '{
        {1'b0, 16'h1020, 32'h00000000, 1'b0},  // R1 R3 reset value, global read
        {1'b1, 16'h1020, 32'hFFFF0000, 1'b0},  // R3 global write all bits
        {1'b0, 16'h2020, 32'h00000000, 1'b0},  // R4 region0 mask zero
        {1'b1, 16'h2020, 32'h0000FFFF, 1'b0},  // R5 fully masked write
        {1'b0, 16'h1020, 32'hFFFF0000, 1'b0},  // R5 unchanged
        {1'b1, 16'h0340, 32'h00FF00FF, 1'b0},  // R9 region0 DMA mask
        {1'b0, 16'h0340, 32'h00FF00FF, 1'b0},  // R9 read back
        {1'b0, 16'h2020, 32'h00FF0000, 1'b0},  // R4 masked read
        {1'b1, 16'h2020, 32'h0000FFFF, 1'b0},  // R5 partial shadow write
        {1'b0, 16'h1020, 32'hFF0000FF, 1'b0},  // R5 mixed result, R2 windows alias
        {1'b1, 16'h2030, 32'hFFFFFFFF, 1'b0},  // R6 shadow set alias
        {1'b0, 16'h1020, 32'hFFFF00FF, 1'b0},  // R6
        {1'b1, 16'h2228, 32'hFFFFFFFF, 1'b0},  // R6 region1 clear, mask zero
        {1'b0, 16'h1020, 32'hFFFF00FF, 1'b0},  // R6 no effect
        {1'b1, 16'h1028, 32'h0F0000F0, 1'b0},  // R6 global clear
        {1'b1, 16'h1030, 32'h00000000, 1'b0},  // R6 zeros in set alias
        {1'b0, 16'h1020, 32'hF0FF000F, 1'b0},  // R6
        {1'b0, 16'h2030, 32'h00000000, 1'b0},  // R6 alias reads zero
        {1'b0, 16'h2340, 32'h00000000, 1'b1},  // R9 mask not in shadow window
        {1'b1, 16'h3000, 32'h12345678, 1'b1},  // R10 undecoded write
        {1'b1, 16'h0388, 32'hFFFFFF0F, 1'b0},  // R9 R7 region2 QDMA mask
        {1'b0, 16'h0388, 32'h0000000F, 1'b0},  // R9 upper bits zero
        {1'b1, 16'h1080, 32'h000000AA, 1'b0},  // R7 global QDMA write
        {1'b0, 16'h2480, 32'h0000000A, 1'b0},  // R7 region2 masked read
        {1'b1, 16'h248C, 32'h000000FF, 1'b0},  // R7 shadow set
        {1'b0, 16'h1080, 32'h000000AF, 1'b0},  // R7
        {1'b0, 16'h2420, 32'h00000000, 1'b0},  // R7 DMA mask of region2 still zero
        {1'b1, 16'h2488, 32'h000000FF, 1'b0},  // R7 shadow clear
        {1'b0, 16'h1080, 32'h000000A0, 1'b0}   // R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one access; sample results one edge later, away from the edge.
    task automatic access(input logic we, input logic [15:0] addr, input logic [31:0] wd);
        bus_en = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 evt_enable", evt_enable, 32'h0);
        check("R1 qevt_enable", {24'h0, qevt_enable}, 32'h0);
        check("R1 reeval_pulse", {31'h0, reeval_pulse}, 32'h0);
        check("R1 bus_err", {31'h0, bus_err}, 32'h0);
        check("R1 bus_rdata", bus_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [49:0] v;
            v = VEC[i];
            access(v[49], v[48:33], v[32:1]);
            if (!v[49]) check($sformatf("vector %0d rdata", i), bus_rdata, v[32:1]);
            check($sformatf("vector %0d err", i), {31'h0, bus_err}, {31'h0, v[0]});
        end
        check("R3 evt_enable port", evt_enable, 32'hF0FF000F);
        check("R7 qevt_enable port", {24'h0, qevt_enable}, 32'h000000A0);

        // R8: strobe through region1 whose masks are zero.
        access(1'b1, 16'h2270, 32'h1);
        check("R8 pulse after shadow write", {31'h0, reeval_pulse}, 32'h1);
        check("R8 no error", {31'h0, bus_err}, 32'h0);
        idle();
        check("R8 pulse one cycle", {31'h0, reeval_pulse}, 32'h0);
        access(1'b1, 16'h1070, 32'h0);
        check("R8 bit0 zero no pulse", {31'h0, reeval_pulse}, 32'h0);
        access(1'b0, 16'h1070, 32'h0);
        check("R8 reads zero", bus_rdata, 32'h0);
        check("R8 ieval no error", {31'h0, bus_err}, 32'h0);

        // R10: misaligned read, one-cycle error.
        access(1'b0, 16'h1022, 32'h0);
        check("R10 misaligned err", {31'h0, bus_err}, 32'h1);
        check("R10 misaligned rdata", bus_rdata, 32'h0);
        idle();
        check("R10 err one cycle", {31'h0, bus_err}, 32'h0);
        check("R11 idle rdata zero", bus_rdata, 32'h0);

        // R1: reset in mid run clears state.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 evt_enable after reset", evt_enable, 32'h0);
        access(1'b0, 16'h0340, 32'h0);
        check("R1 mask after reset", bus_rdata, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule